// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block turns 32-bit virtual addresses into 30-bit physical addresses with 4 KB pages. It is a small fully associative table: every slot compares its stored virtual page against the incoming one in the same cycle. The hit, miss and write-protection results are combinational, so a pipeline can start exception handling on the very next clock. The page offset (the low 12 bits) passes straight through. The upper 18 bits of the physical address come from the matching slot.

The hardware never fetches translations by itself. After a miss, system software reads the latched faulting address. It can also read a ready-made pointer to the page-table entry. It then loads a staging pair of registers with the new translation. Finally it commits the pair with a write-at-index command or a write-at-random command. The random slot comes from a free-running down-counter.

The lookup port has no ready signal. The block accepts a lookup in every cycle in which `lk_valid` is high, so it never applies back-pressure. The register and command pins are plain control pins.

Top module: `swtlb`

## Requirements
- R1: A lookup with `lk_valid` high hits when a valid slot holds the same virtual page (`lk_vaddr[31:12]`). In that same cycle, `lk_hit` is 1 and `lk_paddr` = {slot physical page, `lk_vaddr[11:0]`}. In that cycle `lk_idx`, `lk_perm` and `lk_ref` also give the slot number, its 2 access bits and its stored reference bit.
- R2: A lookup with no valid matching slot raises `lk_miss` in the same cycle. A slot whose valid bit is clear never matches. `exc_target` is 0x8000_0000 while `lk_miss` is high and 0 otherwise. Neither `lk_hit` nor `lk_miss` is raised while `lk_valid` is low.
- R3: On any cycle with `lk_miss` or `lk_modify` set, the full virtual address is captured. From the next cycle it reads back at select 4. Without an exception that register keeps its value.
- R4: Select 5 reads {base[9:0], faulting page[19:0], 2'b00}. A write to select 5 sets the base from `reg_wdata[31:22]` only.
- R5: The random pointer (select 1, read only) is 15 in reset and decreases by one every cycle. It goes from 0 back to 15. Writes to select 1 are ignored.
- R6: Select 0 holds the index (bits 3:0). Select 3 holds the virtual page in bits 31:12. Select 2 holds the physical page in bits 25:8, the reference bit in 4, the writable/dirty bit in 3, the valid bit in 2 and the access bits in 1:0. All other bits of selects 2 and 3 read 0. `cmd_wr_index` copies selects 2 and 3 into the slot named by the index.
- R7: `cmd_wr_random` copies selects 2 and 3 into the slot named by the random pointer's value in that same cycle.
- R8: If both commands are high in one cycle, only the index slot is written.
- R9: A store (`lk_store` = 1) that hits a slot with the dirty bit clear raises `lk_modify` instead of a miss. A load to that slot, or a store to a dirty slot, raises nothing.
- R10: A hit without a modify exception sets the slot's reference bit. A hit that raises a modify exception leaves the bit unchanged.
- R11: When several valid slots hold the same page, the lowest-numbered one supplies the translation.
- R12: After reset every slot is invalid and the index, staging, fault-address and base registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_store | input | 1 | Lookup is a store |
| lk_paddr | output | 30 | Translated physical address (meaningful on hit) |
| lk_hit | output | 1 | Valid translation found |
| lk_miss | output | 1 | No valid translation, exception |
| lk_modify | output | 1 | Store to a clean page, exception |
| lk_idx | output | 4 | Slot that supplied the translation |
| lk_ref | output | 1 | Stored reference bit of that slot |
| lk_perm | output | 2 | Access bits of that slot |
| exc_target | output | 32 | Miss handler address while a miss is flagged |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 3 | Register select (0 index, 1 random, 2 entry low, 3 entry high, 4 fault address, 5 context) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents, combinational |
| cmd_wr_index | input | 1 | Commit staging pair at the index slot |
| cmd_wr_random | input | 1 | Commit staging pair at the random slot |

## Verification
A corrupted slot shows up at the ports in the same cycle as the first lookup to its page. It appears as a wrong physical page, a wrong slot number, a false miss or a missing write-protect exception. The reference bit is an exception: its error shows only on the next hit to that slot. A random pointer that drifts is visible on the very next read of select 1. It also shows after a write-at-random, in the `lk_idx` of a following lookup. A fault address that fails to latch, or latches when it should not, is visible one cycle after the lookup, both at select 4 and at the context register.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 30;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PERM_W = 2;
  localparam int BASE_W = VA_W - VPN_W - 2;

  // register selects
  localparam logic [2:0] SEL_INDEX = 3'd0;
  localparam logic [2:0] SEL_RAND  = 3'd1;
  localparam logic [2:0] SEL_LO    = 3'd2;
  localparam logic [2:0] SEL_HI    = 3'd3;
  localparam logic [2:0] SEL_BAD   = 3'd4;
  localparam logic [2:0] SEL_CTX   = 3'd5;

  // staging-low layout: ppn [25:8], ref 4, dirty 3, valid 2, perm [1:0]
  localparam int LO_PPN_LSB = 8;
  localparam logic [31:0] LO_MASK = 32'h03FF_FF1F;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic              dirty;
    logic              refd;
    logic [PERM_W-1:0] perm;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst)             ptr <= TOP;
    else if (ptr == '0)  ptr <= TOP;
    else                 ptr <= ptr - 1'b1;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import swtlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  tlb_entry_t       wr_entry,
  input  logic             ref_set,
  input  logic [IW-1:0]    ref_idx,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             match_any,
  output logic [IW-1:0]    match_idx,
  output tlb_entry_t       match_entry
);
  tlb_entry_t         slot_q [ENTRIES];
  logic [ENTRIES-1:0] hitv;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst)
        slot_q[i] <= '0;
      else if (wr_en && wr_idx == IW'(i))
        slot_q[i] <= wr_entry;
      else if (ref_set && ref_idx == IW'(i))
        slot_q[i].refd <= 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitv[g] = slot_q[g].valid && (slot_q[g].vpn == look_vpn);
  end

  // lowest-numbered matching slot wins
  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hitv[i]) match_idx = IW'(i);
  end

  assign match_any   = |hitv;
  assign match_entry = slot_q[match_idx];
endmodule

// File: rtl/swtlb.sv
module swtlb
  import swtlb_pkg::*;
#(
  parameter int          ENTRIES     = 16,
  parameter logic [31:0] MISS_VECTOR = 32'h8000_0000,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_store,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_modify,
  output logic [IW-1:0]    lk_idx,
  output logic             lk_ref,
  output logic [PERM_W-1:0] lk_perm,
  output logic [31:0]      exc_target,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             cmd_wr_index,
  input  logic             cmd_wr_random
);
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     rnd_q;
  logic [31:0]       lo_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [VA_W-1:0]   bad_q;
  logic [BASE_W-1:0] base_q;

  logic             match_any;
  logic [IW-1:0]    match_idx;
  tlb_entry_t       match_entry;
  tlb_entry_t       wr_entry;
  logic             wr_en;
  logic [IW-1:0]    wr_idx;
  logic             exc;

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_rnd (
    .clk (clk),
    .rst (rst),
    .ptr (rnd_q)
  );

  // staging pair -> slot image
  always_comb begin
    wr_entry.valid = lo_q[2];
    wr_entry.vpn   = vpn_q;
    wr_entry.ppn   = lo_q[LO_PPN_LSB +: PPN_W];
    wr_entry.dirty = lo_q[3];
    wr_entry.refd  = lo_q[4];
    wr_entry.perm  = lo_q[PERM_W-1:0];
  end

  // index command has priority over random command
  assign wr_en  = cmd_wr_index | cmd_wr_random;
  assign wr_idx = cmd_wr_index ? idx_q : rnd_q;

  tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_entry    (wr_entry),
    .ref_set     (lk_hit & ~lk_modify),
    .ref_idx     (match_idx),
    .look_vpn    (lk_vaddr[VA_W-1:OFF_W]),
    .match_any   (match_any),
    .match_idx   (match_idx),
    .match_entry (match_entry)
  );

  // same-cycle lookup results
  assign lk_hit     = lk_valid & match_any;
  assign lk_miss    = lk_valid & ~match_any;
  assign lk_modify  = lk_hit & lk_store & ~match_entry.dirty;
  assign lk_paddr   = {match_entry.ppn, lk_vaddr[OFF_W-1:0]};
  assign lk_idx     = match_idx;
  assign lk_ref     = match_entry.refd;
  assign lk_perm    = match_entry.perm;
  assign exc_target = lk_miss ? MISS_VECTOR : 32'h0;
  assign exc        = lk_miss | lk_modify;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      lo_q   <= '0;
      vpn_q  <= '0;
      bad_q  <= '0;
      base_q <= '0;
    end else begin
      if (exc) bad_q <= lk_vaddr;
      if (reg_wr) begin
        case (reg_sel)
          SEL_INDEX: idx_q  <= reg_wdata[IW-1:0];
          SEL_LO:    lo_q   <= reg_wdata & LO_MASK;
          SEL_HI:    vpn_q  <= reg_wdata[VA_W-1:OFF_W];
          SEL_CTX:   base_q <= reg_wdata[31 -: BASE_W];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_INDEX: reg_rdata = 32'(idx_q);
      SEL_RAND:  reg_rdata = 32'(rnd_q);
      SEL_LO:    reg_rdata = lo_q;
      SEL_HI:    reg_rdata = {vpn_q, {OFF_W{1'b0}}};
      SEL_BAD:   reg_rdata = bad_q;
      SEL_CTX:   reg_rdata = {base_q, bad_q[VA_W-1:OFF_W], 2'b00};
      default:   reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/swtlb_sva.sv
module swtlb_sva #(
  parameter int          ENTRIES     = 16,
  parameter logic [31:0] MISS_VECTOR = 32'h8000_0000,
  localparam int IW = $clog2(ENTRIES)
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic [31:0]   lk_vaddr,
  input logic          lk_store,
  input logic [11:0]   lk_off,
  input logic          lk_hit,
  input logic          lk_miss,
  input logic          lk_modify,
  input logic [31:0]   exc_target,
  input logic [IW-1:0] rnd,
  input logic [31:0]   bad
);
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_off == lk_vaddr[11:0]); // R1
  AST_MISS_VECTOR: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (exc_target == MISS_VECTOR) && !lk_hit); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_miss && !lk_hit && !lk_modify); // R2
  AST_BAD_LATCH: assert property (@(posedge clk) disable iff (rst)
    (lk_miss || lk_modify) |=> bad == $past(lk_vaddr)); // R3
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(lk_miss || lk_modify) |=> $stable(bad)); // R3
  AST_RND_STEP: assert property (@(posedge clk) disable iff (rst)
    (rnd != '0) |=> rnd == IW'($past(rnd) - 1'b1)); // R5
  AST_RND_WRAP: assert property (@(posedge clk) disable iff (rst)
    (rnd == '0) |=> rnd == IW'(ENTRIES - 1)); // R5
  AST_MODIFY_STORE: assert property (@(posedge clk) disable iff (rst)
    lk_modify |-> lk_store && lk_hit && !lk_miss); // R9
endmodule

bind swtlb swtlb_sva #(.ENTRIES(ENTRIES), .MISS_VECTOR(MISS_VECTOR)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_store   (lk_store),
  .lk_off     (lk_paddr[11:0]),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_modify  (lk_modify),
  .exc_target (exc_target),
  .rnd        (rnd_q),
  .bad        (bad_q)
);

// File: tb/swtlb_test.sv
module swtlb_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_store;
  logic [31:0] lk_vaddr;
  logic [29:0] lk_paddr;
  logic        lk_hit, lk_miss, lk_modify, lk_ref;
  logic [3:0]  lk_idx;
  logic [1:0]  lk_perm;
  logic [31:0] exc_target;
  logic        reg_wr;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_wr_index, cmd_wr_random;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_bad = 32'h0;

  always #2 clk = ~clk;

  swtlb uut (.*);

  // {va[32], store, hit, miss, modify, paddr[30]}
  typedef logic [65:0] vec_t;
  localparam vec_t VT [6] = '{
    {32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0, 18'h00ABC, 12'h678},
    {32'h1234_5FFF, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00ABC, 12'hFFF},
    {32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 18'h3FFFF, 12'h000},
    {32'h0000_1004, 1'b1, 1'b1, 1'b0, 1'b1, 18'h3FFFF, 12'h004},
    {32'h0BEE_F123, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 12'h000},
    {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 12'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rdreg(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wrreg(input logic [2:0] s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] mklo(input logic [17:0] ppn, input logic rf,
                                       input logic dt, input logic vl, input logic [1:0] pm);
    return {6'b0, ppn, 3'b0, rf, dt, vl, pm};
  endfunction

  task automatic stage(input logic [19:0] vpn, input logic [31:0] lo);
    wrreg(3'd2, lo);
    wrreg(3'd3, {vpn, 12'h000});
  endtask

  task automatic put(input int idx, input logic [19:0] vpn, input logic [31:0] lo);
    wrreg(3'd0, 32'(idx));
    stage(vpn, lo);
    cmd_wr_index = 1'b1; step(); cmd_wr_index = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic st);
    lk_valid = 1'b1; lk_vaddr = va; lk_store = st; #1;
  endtask

  task automatic unlook();
    step(); lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r;
    rst = 1'b1; lk_valid = 0; lk_store = 0; lk_vaddr = 0;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0; cmd_wr_index = 0; cmd_wr_random = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R12 / R5 reset state
    rdreg(3'd1, v); chk("R5 random after reset", v, 32'd15);
    rdreg(3'd0, v); chk("R12 index reset", v, 32'h0);
    rdreg(3'd2, v); chk("R12 entry low reset", v, 32'h0);
    rdreg(3'd3, v); chk("R12 entry high reset", v, 32'h0);
    rdreg(3'd4, v); chk("R12 fault address reset", v, 32'h0);
    rdreg(3'd5, v); chk("R12 context reset", v, 32'h0);
    look(32'h1234_5678, 1'b0);
    chk("R12 all slots invalid", {31'b0, lk_miss}, 32'd1);
    exp_bad = 32'h1234_5678;
    unlook();

    // R6 fill slots
    put(0, 20'h12345, mklo(18'h00ABC, 0, 1, 1, 2'b01));
    put(1, 20'h00001, mklo(18'h3FFFF, 0, 0, 1, 2'b10));
    put(2, 20'h0BEEF, mklo(18'h11111, 0, 1, 0, 2'b11));
    put(5, 20'h12345, mklo(18'h22222, 0, 1, 1, 2'b00));

    // vector table: R1 R2 R9 R3
    for (int i = 0; i < 6; i++) begin
      vec_t t = VT[i];
      look(t[65:34], t[33]);
      chk("R1 hit flag", {31'b0, lk_hit}, {31'b0, t[32]});
      chk("R2 miss flag", {31'b0, lk_miss}, {31'b0, t[31]});
      chk("R9 modify flag", {31'b0, lk_modify}, {31'b0, t[30]});
      chk("R2 exc target", exc_target, t[31] ? 32'h8000_0000 : 32'h0);
      if (t[32]) chk("R1 paddr", {2'b0, lk_paddr}, {2'b0, t[29:0]});
      if (t[31] || t[30]) exp_bad = t[65:34];
      unlook();
      rdreg(3'd4, v); chk("R3 fault address", v, exp_bad);
    end

    // R11 priority, R1 perm/idx
    look(32'h1234_5000, 1'b0);
    chk("R11 lowest slot", 32'(lk_idx), 32'd0);
    chk("R11 lowest ppn", {2'b0, lk_paddr}, {2'b0, 18'h00ABC, 12'h000});
    chk("R1 perm bits", 32'(lk_perm), 32'd1);
    unlook();
    look(32'h0000_1000, 1'b0);
    chk("R1 perm slot1", 32'(lk_perm), 32'd2);
    chk("R1 idx slot1", 32'(lk_idx), 32'd1);
    unlook();

    // R10 reference bit
    put(3, 20'h00333, mklo(18'h00333, 0, 1, 1, 2'b00));
    look(32'h0033_3000, 1'b0);
    chk("R10 ref clear before hit", {31'b0, lk_ref}, 32'd0);
    unlook();
    look(32'h0033_3000, 1'b0);
    chk("R10 ref set after hit", {31'b0, lk_ref}, 32'd1);
    unlook();
    put(4, 20'h00444, mklo(18'h00444, 0, 0, 1, 2'b00));
    look(32'h0044_4010, 1'b1);
    chk("R9 modify on clean store", {31'b0, lk_modify}, 32'd1);
    unlook();
    look(32'h0044_4010, 1'b1);
    chk("R10 modify leaves ref", {31'b0, lk_ref}, 32'd0);
    unlook();
    look(32'h0044_4010, 1'b0);
    chk("R9 load to clean page quiet", {31'b0, lk_modify | lk_miss}, 32'd0);
    unlook();
    look(32'h0044_4010, 1'b0);
    chk("R10 ref after load hit", {31'b0, lk_ref}, 32'd1);
    unlook();

    // R4 context
    wrreg(3'd5, 32'hFFFF_FFFF);
    look(32'hABCD_E123, 1'b0);
    chk("R2 miss unmapped", {31'b0, lk_miss}, 32'd1);
    unlook();
    rdreg(3'd5, v); chk("R4 context", v, {10'h3FF, 20'hABCDE, 2'b00});

    // R6 staging layout
    wrreg(3'd2, 32'hFFFF_FFFF);
    rdreg(3'd2, v); chk("R6 entry low mask", v, 32'h03FF_FF1F);
    wrreg(3'd3, 32'hFFFF_FFFF);
    rdreg(3'd3, v); chk("R6 entry high mask", v, 32'hFFFF_F000);

    // R5 random stepping and ignored write
    rdreg(3'd1, r);
    step();
    rdreg(3'd1, v); chk("R5 decrement", v, (r - 32'd1) & 32'hF);
    rdreg(3'd1, r);
    wrreg(3'd1, 32'h5);
    rdreg(3'd1, v); chk("R5 write ignored", v, (r - 32'd1) & 32'hF);
    rdreg(3'd1, r);
    repeat (16) step();
    rdreg(3'd1, v); chk("R5 wrap period", v, r);

    // R7 write at random
    stage(20'h0CAFE, mklo(18'h0CAFE, 0, 1, 1, 2'b00));
    rdreg(3'd1, r);
    cmd_wr_random = 1'b1; step(); cmd_wr_random = 1'b0;
    look(32'h0CAF_E000, 1'b0);
    chk("R7 random slot hit", {31'b0, lk_hit}, 32'd1);
    chk("R7 random slot", 32'(lk_idx), r);
    unlook();

    // R8 both commands: index wins
    wrreg(3'd0, 32'd15);
    stage(20'h0D00D, mklo(18'h0D00D, 0, 1, 1, 2'b00));
    rdreg(3'd1, r);
    while (r == 32'd15) begin
      step();
      rdreg(3'd1, r);
    end
    cmd_wr_index = 1'b1; cmd_wr_random = 1'b1; step();
    cmd_wr_index = 1'b0; cmd_wr_random = 1'b0;
    look(32'h0D00_D000, 1'b0);
    chk("R8 index wins", 32'(lk_idx), 32'd15);
    chk("R8 hit", {31'b0, lk_hit}, 32'd1);
    unlook();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule